// File: doc/BRIEF.md
# USB endpoint buffer descriptor engine

This block serves one device endpoint in both directions. Transfers are driven by buffer descriptors that firmware hands over, not by a plain FIFO. Four descriptors sit in a small local store: an even and an odd one for the IN direction and an even and an odd one for the OUT direction. Each descriptor has a status word and an address word. The status word holds a hardware-ownership bit, the expected DATA0/DATA1 toggle, an overflow flag and a byte count. The address word holds the start of the data buffer in a byte-wide buffer RAM that is local to the block.

Firmware fills the buffer RAM and a descriptor, then sets the ownership bit. When a token arrives, the engine picks the active descriptor for that direction through a per-direction even/odd pointer and checks ownership. For an IN token it streams the buffer out on a byte port framed by start and end strobes. For an OUT token it stores the received byte stream into the buffer. On completion it rewrites the status word, gives the descriptor back to firmware, flips the even/odd pointer and raises a sticky transfer-complete flag. Firmware clears that flag by writing 1.

A token on a descriptor that firmware still owns gets a one-cycle NAK pulse, and nothing is changed. An OUT packet whose toggle does not match is thrown away, and its descriptor stays armed.

Top module: `ep_bd_engine`

## Requirements
- R1: After reset every descriptor status and address word reads 0, the transfer-complete flag is 0, and tx_sop, tx_valid, tx_eop, rsp_nak and busy are all 0.
- R2: Descriptor index bit 1 selects the direction (1 = IN, 0 = OUT) and bit 0 selects odd. Status word layout: bit 15 = owned by hardware, bit 14 = DATA1 toggle, bit 13 = overflow, bits 12:0 = byte count. An IN token arriving on an owned descriptor causes the following, with no gaps:
  - tx_sop is high the cycle after the token, with tx_data1 equal to the toggle bit.
  - Then come count cycles of tx_valid, carrying buffer bytes at address+i modulo the RAM size.
  - Then tx_eop follows. A count of 0 gives tx_sop followed directly by tx_eop.
- R3: On IN completion the status word becomes own=0, overflow=0, with the toggle and count unchanged. The flag is set, and that direction's even/odd pointer flips so that the next token of the same direction uses the other descriptor. The other direction's pointer is not affected.
- R4: A token whose active descriptor has own=0 gives rsp_nak high for exactly the cycle after the token. No packet is sent, no descriptor word, buffer byte or pointer changes, and the flag is not set.
- R5: An OUT token whose toggle equals the owned descriptor's toggle bit causes the following:
  - Each received byte i is stored at address+i. A byte presented together with rx_end is included.
  - rx_end starts write-back: status becomes own=0, toggle unchanged, overflow=0, count = bytes received.
  - The flag is set and the OUT pointer flips.
- R6: An OUT packet longer than the descriptor count stores only the first count bytes. No byte beyond the buffer is written, and the status gets overflow=1 and count = the descriptor count.
- R7: An OUT packet whose toggle differs from the descriptor toggle is discarded. The buffer is untouched, the descriptor stays armed and unchanged, the pointer does not move, the flag is not set and no NAK is given.
- R8: The transfer-complete flag stays set until fw_flag_clr is pulsed. If a completion and a clear fall in the same cycle, the flag ends up set.
- R9: While busy is high (a transfer in progress), incoming tokens are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_bd_we | input | 1 | Firmware descriptor word write strobe |
| fw_bd_idx | input | 2 | Descriptor index {IN, odd} |
| fw_bd_word | input | 1 | 0 = status word, 1 = address word |
| fw_bd_wdata | input | 16 | Descriptor write data |
| fw_bd_rdata | output | 16 | Selected descriptor word (combinational) |
| fw_ram_we | input | 1 | Firmware buffer RAM write strobe |
| fw_ram_addr | input | AW | Firmware buffer RAM address |
| fw_ram_wdata | input | 8 | Firmware buffer RAM write data |
| fw_ram_rdata | output | 8 | Buffer RAM read data (combinational) |
| fw_flag_clr | input | 1 | Write-1 clear of the transfer-complete flag |
| trn_flag | output | 1 | Sticky transfer-complete flag |
| tok_valid | input | 1 | Token strobe |
| tok_in | input | 1 | 1 = IN token, 0 = OUT token |
| tok_data1 | input | 1 | Toggle of the OUT data packet |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | End of received packet |
| tx_sop | output | 1 | Transmit packet start |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_eop | output | 1 | Transmit packet end |
| tx_data1 | output | 1 | Toggle of the transmitted packet |
| rsp_nak | output | 1 | NAK response pulse |
| busy | output | 1 | Transfer in progress |

## Verification
IN transfers are swept over byte counts 0 to 20, alternating between even and odd descriptors with start addresses that wrap past the top of the RAM. The varied counts and addresses separate off-by-one and wrap errors, and the alternation shows whether the pointer flips. OUT transfers are swept over every packet length from 0 to count+2 for several buffer sizes, against a sentinel-filled region. This separates an exact fit from a short packet and from an overflow, and exposes any stray write past the buffer. Separate patterns cover a token on a descriptor firmware still owns, a toggle mismatch, a token injected during a transfer, and a flag clear that lands in the same cycle as a completion.

// File: rtl/ep_bd_pkg.sv
`timescale 1ns/1ps
package ep_bd_pkg;

    localparam int unsigned NUM_BD   = 4;
    localparam int unsigned BD_IDX_W = $clog2(NUM_BD);
    localparam int unsigned STAT_W   = 16;
    localparam int unsigned CF_W     = 13;

    typedef struct packed {
        logic            own;
        logic            data1;
        logic            ovf;
        logic [CF_W-1:0] cnt;
    } bd_stat_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_SOP,
        ST_TX_BYTE,
        ST_TX_EOP,
        ST_RX,
        ST_WB,
        ST_DRAIN
    } eng_state_e;

    function automatic logic [BD_IDX_W-1:0] bd_index(input logic dir_in, input logic odd);
        return {dir_in, odd};
    endfunction

endpackage

// File: rtl/ep_bd_store.sv
`timescale 1ns/1ps
module ep_bd_store
    import ep_bd_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fw_we,
    input  logic [BD_IDX_W-1:0] fw_idx,
    input  logic                fw_word,
    input  logic [STAT_W-1:0]   fw_wdata,
    output logic [STAT_W-1:0]   fw_rdata,
    input  logic [BD_IDX_W-1:0] eng_idx,
    output logic [STAT_W-1:0]   eng_stat,
    output logic [AW-1:0]       eng_addr,
    input  logic                wb_we,
    input  logic [BD_IDX_W-1:0] wb_idx,
    input  logic [STAT_W-1:0]   wb_stat
);

    logic [STAT_W-1:0] stat_q [NUM_BD];
    logic [AW-1:0]     addr_q [NUM_BD];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BD; i++) begin
                stat_q[i] <= '0;
                addr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_BD; i++) begin
                if (wb_we && wb_idx == BD_IDX_W'(i)) begin
                    stat_q[i] <= wb_stat;
                end else if (fw_we && !fw_word && fw_idx == BD_IDX_W'(i)) begin
                    stat_q[i] <= fw_wdata;
                end
                if (fw_we && fw_word && fw_idx == BD_IDX_W'(i)) begin
                    addr_q[i] <= fw_wdata[AW-1:0];
                end
            end
        end
    end

    assign fw_rdata = fw_word ? STAT_W'(addr_q[fw_idx]) : stat_q[fw_idx];
    assign eng_stat = stat_q[eng_idx];
    assign eng_addr = addr_q[eng_idx];

endmodule

// File: rtl/ep_buf_ram.sv
`timescale 1ns/1ps
module ep_buf_ram #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          fw_we,
    input  logic [AW-1:0] fw_addr,
    input  logic [7:0]    fw_wdata,
    output logic [7:0]    fw_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [7:0]    eng_wdata,
    output logic [7:0]    eng_rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem[eng_addr] <= eng_wdata;
        end
        if (fw_we && !(eng_we && eng_addr == fw_addr)) begin
            mem[fw_addr] <= fw_wdata;
        end
    end

    assign fw_rdata  = mem[fw_addr];
    assign eng_rdata = mem[eng_addr];

endmodule

// File: rtl/ep_bd_ctrl.sv
`timescale 1ns/1ps
module ep_bd_ctrl
    import ep_bd_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned CNT_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tok_valid,
    input  logic                tok_in,
    input  logic                tok_data1,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_end,
    output logic                tx_sop,
    output logic                tx_valid,
    output logic [7:0]          tx_data,
    output logic                tx_eop,
    output logic                tx_data1,
    output logic                rsp_nak,
    output logic                busy,
    output logic                done,
    output logic [BD_IDX_W-1:0] rd_idx,
    input  logic [STAT_W-1:0]   rd_stat,
    input  logic [AW-1:0]       rd_addr,
    output logic                wb_we,
    output logic [BD_IDX_W-1:0] wb_idx,
    output logic [STAT_W-1:0]   wb_stat,
    output logic                ram_we,
    output logic [AW-1:0]       ram_addr,
    output logic [7:0]          ram_wdata,
    input  logic [7:0]          ram_rdata
);

    eng_state_e          state_q;
    logic [BD_IDX_W-1:0] idx_q;
    logic [AW-1:0]       addr_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    k_q;
    logic                d1_q;
    logic                ovf_q;
    logic [1:0]          pp_q;
    logic                nak_q;
    bd_stat_t            bd_now;
    bd_stat_t            wb_s;
    logic                room;
    logic                unused_cnt_hi;

    assign rd_idx        = bd_index(tok_in, pp_q[tok_in]);
    assign bd_now        = bd_stat_t'(rd_stat);
    assign unused_cnt_hi = ^bd_now.cnt[CF_W-1:CNT_W];
    assign room          = (k_q < cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            k_q     <= '0;
            d1_q    <= 1'b0;
            ovf_q   <= 1'b0;
            pp_q    <= '0;
            nak_q   <= 1'b0;
        end else begin
            nak_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (tok_valid) begin
                        idx_q  <= rd_idx;
                        addr_q <= rd_addr;
                        cnt_q  <= bd_now.cnt[CNT_W-1:0];
                        d1_q   <= bd_now.data1;
                        k_q    <= '0;
                        ovf_q  <= 1'b0;
                        if (!bd_now.own) begin
                            nak_q   <= 1'b1;
                            state_q <= tok_in ? ST_IDLE : ST_DRAIN;
                        end else if (tok_in) begin
                            state_q <= ST_TX_SOP;
                        end else if (tok_data1 != bd_now.data1) begin
                            state_q <= ST_DRAIN;
                        end else begin
                            state_q <= ST_RX;
                        end
                    end
                end
                ST_TX_SOP: begin
                    state_q <= (cnt_q == '0) ? ST_TX_EOP : ST_TX_BYTE;
                end
                ST_TX_BYTE: begin
                    k_q <= k_q + CNT_W'(1);
                    if (k_q == cnt_q - CNT_W'(1)) begin
                        state_q <= ST_TX_EOP;
                    end
                end
                ST_RX: begin
                    if (rx_valid) begin
                        if (room) begin
                            k_q <= k_q + CNT_W'(1);
                        end else begin
                            ovf_q <= 1'b1;
                        end
                    end
                    if (rx_end) begin
                        state_q <= ST_WB;
                    end
                end
                ST_TX_EOP, ST_WB: begin
                    pp_q[idx_q[1]] <= ~pp_q[idx_q[1]];
                    state_q        <= ST_IDLE;
                end
                ST_DRAIN: begin
                    if (rx_end) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wb_s       = '0;
        wb_s.own   = 1'b0;
        wb_s.data1 = d1_q;
        wb_s.ovf   = (state_q == ST_WB) ? ovf_q : 1'b0;
        wb_s.cnt   = (state_q == ST_WB) ? CF_W'(k_q) : CF_W'(cnt_q);
    end

    assign wb_we     = (state_q == ST_TX_EOP) || (state_q == ST_WB);
    assign wb_idx    = idx_q;
    assign wb_stat   = wb_s;
    assign done      = wb_we;
    assign ram_addr  = addr_q + AW'(k_q);
    assign ram_we    = (state_q == ST_RX) && rx_valid && room;
    assign ram_wdata = rx_data;
    assign tx_sop    = (state_q == ST_TX_SOP);
    assign tx_valid  = (state_q == ST_TX_BYTE);
    assign tx_eop    = (state_q == ST_TX_EOP);
    assign tx_data   = tx_valid ? ram_rdata : 8'h00;
    assign tx_data1  = d1_q;
    assign rsp_nak   = nak_q;
    assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/ep_bd_engine.sv
`timescale 1ns/1ps
module ep_bd_engine
    import ep_bd_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned CNT_W = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fw_bd_we,
    input  logic [1:0]    fw_bd_idx,
    input  logic          fw_bd_word,
    input  logic [15:0]   fw_bd_wdata,
    output logic [15:0]   fw_bd_rdata,
    input  logic          fw_ram_we,
    input  logic [AW-1:0] fw_ram_addr,
    input  logic [7:0]    fw_ram_wdata,
    output logic [7:0]    fw_ram_rdata,
    input  logic          fw_flag_clr,
    output logic          trn_flag,
    input  logic          tok_valid,
    input  logic          tok_in,
    input  logic          tok_data1,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_end,
    output logic          tx_sop,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_eop,
    output logic          tx_data1,
    output logic          rsp_nak,
    output logic          busy
);

    logic [BD_IDX_W-1:0] rd_idx;
    logic [STAT_W-1:0]   rd_stat;
    logic [AW-1:0]       rd_addr;
    logic                wb_we;
    logic [BD_IDX_W-1:0] wb_idx;
    logic [STAT_W-1:0]   wb_stat;
    logic                ram_we;
    logic [AW-1:0]       ram_addr;
    logic [7:0]          ram_wdata;
    logic [7:0]          ram_rdata;
    logic                done;
    logic                flag_q;

    ep_bd_store #(.AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .fw_we    (fw_bd_we),
        .fw_idx   (fw_bd_idx),
        .fw_word  (fw_bd_word),
        .fw_wdata (fw_bd_wdata),
        .fw_rdata (fw_bd_rdata),
        .eng_idx  (rd_idx),
        .eng_stat (rd_stat),
        .eng_addr (rd_addr),
        .wb_we    (wb_we),
        .wb_idx   (wb_idx),
        .wb_stat  (wb_stat)
    );

    ep_buf_ram #(.AW(AW)) u_ram (
        .clk       (clk),
        .fw_we     (fw_ram_we),
        .fw_addr   (fw_ram_addr),
        .fw_wdata  (fw_ram_wdata),
        .fw_rdata  (fw_ram_rdata),
        .eng_we    (ram_we),
        .eng_addr  (ram_addr),
        .eng_wdata (ram_wdata),
        .eng_rdata (ram_rdata)
    );

    ep_bd_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tok_valid (tok_valid),
        .tok_in    (tok_in),
        .tok_data1 (tok_data1),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_end    (rx_end),
        .tx_sop    (tx_sop),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_eop    (tx_eop),
        .tx_data1  (tx_data1),
        .rsp_nak   (rsp_nak),
        .busy      (busy),
        .done      (done),
        .rd_idx    (rd_idx),
        .rd_stat   (rd_stat),
        .rd_addr   (rd_addr),
        .wb_we     (wb_we),
        .wb_idx    (wb_idx),
        .wb_stat   (wb_stat),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata)
    );

    // Sticky completion flag: a completion outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (done) begin
            flag_q <= 1'b1;
        end else if (fw_flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign trn_flag = flag_q;

endmodule

// File: rtl/ep_bd_engine_chk.sv
`timescale 1ns/1ps
module ep_bd_engine_chk (
    input logic clk,
    input logic rst,
    input logic fw_flag_clr,
    input logic trn_flag,
    input logic tx_sop,
    input logic tx_valid,
    input logic tx_eop,
    input logic rsp_nak,
    input logic busy
);

    p_tx_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_sop, tx_valid, tx_eop}));

    p_tx_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_sop || tx_valid || tx_eop) |-> busy);

    p_sop_follow_r2: assert property (@(posedge clk) disable iff (rst)
        tx_sop |=> (tx_valid || tx_eop));

    p_eop_flag_r3: assert property (@(posedge clk) disable iff (rst)
        tx_eop |=> trn_flag);

    p_eop_idle_r3: assert property (@(posedge clk) disable iff (rst)
        tx_eop |=> !busy);

    p_nak_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_nak |-> !(tx_sop || tx_valid || tx_eop));

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (trn_flag && !fw_flag_clr) |=> trn_flag);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (fw_flag_clr && !busy) |=> !trn_flag);

endmodule

bind ep_bd_engine ep_bd_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fw_flag_clr (fw_flag_clr),
    .trn_flag    (trn_flag),
    .tx_sop      (tx_sop),
    .tx_valid    (tx_valid),
    .tx_eop      (tx_eop),
    .rsp_nak     (rsp_nak),
    .busy        (busy)
);

// File: tb/test_ep_bd_engine.sv
`timescale 1ns/1ps
module test_ep_bd_engine;

    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          fw_bd_we;
    logic [1:0]    fw_bd_idx;
    logic          fw_bd_word;
    logic [15:0]   fw_bd_wdata;
    logic [15:0]   fw_bd_rdata;
    logic          fw_ram_we;
    logic [AW-1:0] fw_ram_addr;
    logic [7:0]    fw_ram_wdata;
    logic [7:0]    fw_ram_rdata;
    logic          fw_flag_clr;
    logic          trn_flag;
    logic          tok_valid, tok_in, tok_data1;
    logic          rx_valid, rx_end;
    logic [7:0]    rx_data;
    logic          tx_sop, tx_valid, tx_eop, tx_data1;
    logic [7:0]    tx_data;
    logic          rsp_nak, busy;

    ep_bd_engine #(.AW(AW), .CNT_W(7)) i_ep_bd_engine (.*);

    always #2 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] got_b [256];
    int         got_n;
    logic       got_nak, got_sop, got_d1, got_eop;
    logic [15:0] s;
    logic [7:0]  rb;
    logic [7:0]  a;
    logic [1:0]  idx;
    logic        d1;
    logic        pp_in, pp_out;
    int          mism, stored;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int adr);
        return 8'((adr % 256) * 37 + 11);
    endfunction

    task automatic bd_wr(input logic [1:0] i, input logic w, input logic [15:0] v);
        @(negedge clk);
        fw_bd_we = 1'b1; fw_bd_idx = i; fw_bd_word = w; fw_bd_wdata = v;
        @(negedge clk);
        fw_bd_we = 1'b0;
    endtask

    task automatic bd_rd(input logic [1:0] i, input logic w, output logic [15:0] v);
        @(negedge clk);
        fw_bd_idx = i; fw_bd_word = w;
        #1 v = fw_bd_rdata;
    endtask

    task automatic ram_wr(input logic [7:0] ad, input logic [7:0] v);
        @(negedge clk);
        fw_ram_we = 1'b1; fw_ram_addr = ad; fw_ram_wdata = v;
        @(negedge clk);
        fw_ram_we = 1'b0;
    endtask

    task automatic ram_rd(input logic [7:0] ad, output logic [7:0] v);
        @(negedge clk);
        fw_ram_addr = ad;
        #1 v = fw_ram_rdata;
    endtask

    task automatic arm(input logic [1:0] i, input logic [7:0] ad, input logic t, input int c);
        bd_wr(i, 1'b1, 16'(ad));
        bd_wr(i, 1'b0, {1'b1, t, 1'b0, 13'(c)});
    endtask

    task automatic flag_clr_pulse();
        @(negedge clk);
        fw_flag_clr = 1'b1;
        @(negedge clk);
        fw_flag_clr = 1'b0;
    endtask

    // mode 0: plain, 1: clear flag in the write-back cycle, 2: inject OUT token at SOP
    task automatic run_in(input int mode);
        got_n = 0; got_nak = 0; got_sop = 0; got_d1 = 0; got_eop = 0;
        @(negedge clk);
        tok_valid = 1'b1; tok_in = 1'b1;
        @(negedge clk);
        tok_valid = 1'b0;
        for (int it = 0; it < 300; it++) begin
            tok_valid = (mode == 2 && it == 0);
            tok_in    = (mode == 2 && it == 0) ? 1'b0 : 1'b1;
            tok_data1 = 1'b0;
            if (rsp_nak) begin got_nak = 1; break; end
            if (tx_sop) begin got_sop = 1; got_d1 = tx_data1; end
            if (tx_valid) begin got_b[got_n] = tx_data; got_n++; end
            if (tx_eop) begin
                got_eop = 1;
                if (mode == 1) fw_flag_clr = 1'b1;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        fw_flag_clr = 1'b0; tok_valid = 1'b0;
    endtask

    task automatic run_out(input logic t, input int len, input int base);
        @(negedge clk);
        tok_valid = 1'b1; tok_in = 1'b0; tok_data1 = t;
        @(negedge clk);
        tok_valid = 1'b0;
        got_nak = rsp_nak;
        if (len == 0) begin
            rx_end = 1'b1;
            @(negedge clk);
        end else begin
            for (int i = 0; i < len; i++) begin
                rx_valid = 1'b1; rx_data = 8'(base + i); rx_end = (i == len - 1);
                @(negedge clk);
            end
        end
        rx_valid = 1'b0; rx_end = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_in_bytes(input string tag, input logic [7:0] ad, input int c);
        mism = 0;
        for (int i = 0; i < c; i++) if (got_b[i] != pat(ad + i)) mism++;
        chk(tag, mism, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        fw_bd_we = 0; fw_bd_idx = 0; fw_bd_word = 0; fw_bd_wdata = 0;
        fw_ram_we = 0; fw_ram_addr = 0; fw_ram_wdata = 0; fw_flag_clr = 0;
        tok_valid = 0; tok_in = 0; tok_data1 = 0; rx_valid = 0; rx_data = 0; rx_end = 0;
        pp_in = 0; pp_out = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            bd_rd(2'(i), 1'b0, s); chk("R1 status reset", s, 0);
            bd_rd(2'(i), 1'b1, s); chk("R1 address reset", s, 0);
        end
        chk("R1 flag reset", trn_flag, 0);
        chk("R1 outputs idle", {tx_sop, tx_valid, tx_eop, rsp_nak, busy}, 0);

        for (int ad = 0; ad < 256; ad++) ram_wr(8'(ad), pat(ad));

        // R2/R3: IN sweep over counts, wrapping addresses, alternating descriptors
        for (int c = 0; c <= 20; c++) begin
            idx = {1'b1, pp_in};
            a   = 8'(c * 13 + 240);
            d1  = c[0];
            arm(idx, a, d1, c);
            flag_clr_pulse();
            run_in(0);
            chk("R2 IN no nak", got_nak, 0);
            chk("R2 IN sop", got_sop, 1);
            chk("R2 IN toggle", got_d1, d1);
            chk("R2 IN byte count", got_n, c);
            check_in_bytes("R2 IN bytes", a, c);
            chk("R2 IN eop", got_eop, 1);
            bd_rd(idx, 1'b0, s);
            chk("R3 IN status written back", s, {1'b0, d1, 1'b0, 13'(c)});
            chk("R3 IN flag set", trn_flag, 1);
            pp_in = ~pp_in;
        end

        // R8: clear, then completion and clear in the same cycle
        flag_clr_pulse();
        chk("R8 flag cleared by write 1", trn_flag, 0);
        idx = {1'b1, pp_in};
        arm(idx, 8'h10, 1'b0, 1);
        run_in(1);
        chk("R8 set wins over clear", trn_flag, 1);
        pp_in = ~pp_in;
        repeat (3) @(negedge clk);
        chk("R8 flag sticky", trn_flag, 1);
        flag_clr_pulse();
        chk("R8 flag cleared", trn_flag, 0);

        // R4: token on a descriptor not owned by hardware
        idx = {1'b1, pp_in};
        bd_wr(idx, 1'b1, 16'h0020);
        bd_wr(idx, 1'b0, {1'b0, 1'b1, 1'b0, 13'd5});
        run_in(0);
        chk("R4 IN nak", got_nak, 1);
        chk("R4 IN no packet", got_sop, 0);
        bd_rd(idx, 1'b0, s);
        chk("R4 descriptor untouched", s, {1'b0, 1'b1, 1'b0, 13'd5});
        chk("R4 flag not set", trn_flag, 0);
        arm(idx, 8'h20, 1'b1, 5);
        run_in(0);
        chk("R4 pointer unchanged after nak", got_nak, 0);
        check_in_bytes("R4 bytes after re-arm", 8'h20, 5);
        pp_in = ~pp_in;
        flag_clr_pulse();

        // R9: OUT token during an IN transfer is ignored
        idx = {1'b1, pp_in};
        arm(idx, 8'h30, 1'b0, 3);
        arm({1'b0, pp_out}, 8'h60, 1'b0, 2);
        run_in(2);
        chk("R9 IN unaffected", got_n, 3);
        check_in_bytes("R9 IN bytes", 8'h30, 3);
        bd_rd({1'b0, pp_out}, 1'b0, s);
        chk("R9 OUT descriptor still armed", s, {1'b1, 1'b0, 1'b0, 13'd2});
        pp_in = ~pp_in;
        run_out(1'b0, 0, 0);
        bd_rd({1'b0, pp_out}, 1'b0, s);
        chk("R5 zero-length OUT", s, {1'b0, 1'b0, 1'b0, 13'd0});
        pp_out = ~pp_out;

        // R5/R6: OUT sweep over buffer sizes and packet lengths
        for (int ci = 0; ci < 4; ci++) begin
            int cap;
            cap = (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? 3 : 8;
            for (int len = 0; len <= cap + 2; len++) begin
                idx = {1'b0, pp_out};
                a   = pp_out ? 8'hF8 : 8'h40;
                d1  = len[0];
                for (int i = 0; i < cap + 3; i++) ram_wr(8'(a + i), 8'hA5);
                arm(idx, a, d1, cap);
                flag_clr_pulse();
                run_out(d1, len, len * 16 + ci);
                stored = (len < cap) ? len : cap;
                chk("R5 OUT no nak", got_nak, 0);
                bd_rd(idx, 1'b0, s);
                chk((len > cap) ? "R6 OUT status overflow" : "R5 OUT status",
                    s, {1'b0, d1, (len > cap), 13'(stored)});
                chk("R5 OUT flag set", trn_flag, 1);
                mism = 0;
                for (int i = 0; i < stored; i++) begin
                    ram_rd(8'(a + i), rb);
                    if (rb != 8'(len * 16 + ci + i)) mism++;
                end
                chk("R5 OUT stored bytes", mism, 0);
                mism = 0;
                for (int i = stored; i < cap + 3; i++) begin
                    ram_rd(8'(a + i), rb);
                    if (rb != 8'hA5) mism++;
                end
                chk("R6 no write past buffer", mism, 0);
                pp_out = ~pp_out;
            end
        end

        // R7: toggle mismatch discards data, descriptor stays armed
        flag_clr_pulse();
        idx = {1'b0, pp_out};
        a   = pp_out ? 8'hF8 : 8'h40;
        for (int i = 0; i < 4; i++) ram_wr(8'(a + i), 8'hA5);
        arm(idx, a, 1'b0, 3);
        run_out(1'b1, 3, 8'h70);
        chk("R7 mismatch no nak", got_nak, 0);
        bd_rd(idx, 1'b0, s);
        chk("R7 descriptor still armed", s, {1'b1, 1'b0, 1'b0, 13'd3});
        chk("R7 flag not set", trn_flag, 0);
        mism = 0;
        for (int i = 0; i < 4; i++) begin
            ram_rd(8'(a + i), rb);
            if (rb != 8'hA5) mism++;
        end
        chk("R7 buffer untouched", mism, 0);
        run_out(1'b0, 3, 8'h70);
        bd_rd(idx, 1'b0, s);
        chk("R7 same descriptor completes next", s, {1'b0, 1'b0, 1'b0, 13'd3});
        chk("R7 flag after match", trn_flag, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule